// File: doc/BRIEF.md
# Complementary PWM Output Stage with Dead-Band

This block sits between a PWM counter and the pins of a half-bridge driver. Each of its four channels takes one raw PWM waveform and drives two pins: a primary pin and a complementary "N" pin. Whenever the raw waveform changes level, the block opens a dead-band window. During that window both pins are held at a safe level, so the two switches of the bridge are never both conducting across a transition.

A per-channel 2-bit mode selects how the N pin behaves:
- it can be handed back to a general-purpose output value;
- it can drive the inverse of the primary, with both pins forced high during dead-band;
- it can drive the inverse of the primary, with both pins forced low during dead-band;
- it can drive a same-polarity copy that is also blanked low during dead-band.

The modes live in a 32-bit control register. A write only lands when it carries the correct key byte. The dead-band length, in clock cycles, comes in on a separate register input.

Top module: `cpwm_deadband`

## Requirements
- R1: A write strobe updates the mode register only when write data bits 31:24 equal 0x5A. Any other key value leaves all mode fields unchanged.
- R2: Read data returns the mode fields in bits 7:0. Every other bit, including the key byte, reads as 0.
- R3: After reset, every mode field is 00, no dead-band is active, every primary pin is low and every N pin shows its GPIO value.
- R4: Channel i's mode sits in bits 2i+1:2i. The encodings are: 00 = GPIO, 01 = inverse with high dead level, 10 = inverse with low dead level, 11 = same polarity.
- R5: In mode 00 the N pin equals the channel's GPIO input combinationally. The primary pin is still dead-banded with a low dead level.
- R6: In mode 01 the N pin is the inverse of the primary outside dead-band, and both pins are high inside it.
- R7: In mode 10 the N pin is the inverse of the primary outside dead-band, and both pins are low inside it.
- R8: In mode 11 the N pin equals the primary pin at all times, and both are low inside dead-band.
- R9: With a non-zero length L, a change of the sampled raw input at a clock edge holds both pins at the dead level for exactly L cycles starting at that edge. After that, the primary pin shows the sampled raw level.
- R10: With length 0 there is no dead-band. The primary pin equals the raw input sampled at the previous edge.
- R11: A raw change sampled while a dead-band window is open reloads the count to L, and the pins stay at the dead level.
- R12: Channels are independent: each uses only its own raw input, GPIO input and mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Single-cycle write strobe for the mode register |
| cfg_wdata | input | 32 | Write data; key byte in bits 31:24 |
| cfg_rdata | output | 32 | Combinational read data of the mode register |
| dead_len | input | 8 | Dead-band length in clock cycles, 0 disables |
| pwm_raw | input | 4 | Raw PWM waveform, one bit per channel |
| gpio_n_val | input | 4 | Value shown on an N pin in mode 00 |
| pwm_p | output | 4 | Primary outputs |
| pwm_n | output | 4 | Complementary outputs |

## Verification
The hardest case to reach is a raw edge that arrives while a window is still counting, especially on the window's final cycle, where a one-off error in the reload would open a one-cycle gap. The stimulus runs a deterministic sweep in which each channel toggles at a fixed spacing from 1 up to L+2 cycles, for every L from 1 to 5. This places edges on every cycle of an open window and just after it closes. A pseudo-random sweep over several mixed mode settings and lengths, including 0, then covers the remaining combinations of modes and edge timing.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic [1:0] {
        NMODE_GPIO   = 2'b00,
        NMODE_INV_HI = 2'b01,
        NMODE_INV_LO = 2'b10,
        NMODE_FOLLOW = 2'b11
    } nmode_e;
endpackage

// File: rtl/cpwm_keyreg.sv
module cpwm_keyreg #(
    parameter int          NCH   = 4,
    parameter int          REG_W = 32,
    parameter int          KEY_W = 8,
    parameter logic [7:0]  KEY   = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [2*NCH-1:0]   modes
);
    localparam int MODE_W  = 2 * NCH;
    localparam int KEY_LSB = REG_W - KEY_W;

    typedef struct packed {
        logic [MODE_W-1:0] modes;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       key_ok;
    logic       unused_mid_bits;

    assign key_ok          = (wdata[REG_W-1:KEY_LSB] == KEY[KEY_W-1:0]);
    assign unused_mid_bits = ^wdata[KEY_LSB-1:MODE_W];

    always_comb begin
        st_d = st_q;
        if (we && key_ok) begin
            st_d.modes = wdata[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign modes = st_q.modes;
    assign rdata = {{(REG_W-MODE_W){1'b0}}, st_q.modes};

    a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[REG_W-1:KEY_LSB] != KEY[KEY_W-1:0]) |=> $stable(modes));

    a_r1_good_key_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[REG_W-1:KEY_LSB] == KEY[KEY_W-1:0])
            |=> (modes == $past(wdata[MODE_W-1:0])));
endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_in,
    input  logic          gpio_in,
    input  nmode_e        mode,
    input  logic [CW-1:0] dead_len,
    output logic          p_out,
    output logic          n_out
);
    localparam logic [CW-1:0] ONE = 1;

    typedef struct packed {
        logic          raw;
        logic [CW-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      edge_seen;
    logic      dead;
    logic      dead_lvl;

    // next state: edge detect and dead-band counter (reload on every edge)
    always_comb begin
        st_d      = st_q;
        edge_seen = (raw_in != st_q.raw);
        st_d.raw  = raw_in;
        if (edge_seen && dead_len != '0) begin
            st_d.cnt = dead_len;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // output steering
    always_comb begin
        dead     = (st_q.cnt != '0);
        dead_lvl = (mode == NMODE_INV_HI);
        p_out    = dead ? dead_lvl : st_q.raw;
        unique case (mode)
            NMODE_GPIO:   n_out = gpio_in;
            NMODE_INV_HI: n_out = dead ? 1'b1 : ~st_q.raw;
            NMODE_INV_LO: n_out = dead ? 1'b0 : ~st_q.raw;
            default:      n_out = dead ? 1'b0 : st_q.raw;
        endcase
    end

    a_r6_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NMODE_INV_HI) |-> (p_out || n_out));

    a_r7_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NMODE_INV_LO) |-> !(p_out && n_out));

    a_r8_follow_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NMODE_FOLLOW) |-> (p_out == n_out));

    a_r9_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_in != st_q.raw && dead_len != '0) |=> (st_q.cnt == $past(dead_len)));

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_in == st_q.raw && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - ONE));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DB_W  = 8,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [DB_W-1:0]  dead_len,
    input  logic [NCH-1:0]   pwm_raw,
    input  logic [NCH-1:0]   gpio_n_val,
    output logic [NCH-1:0]   pwm_p,
    output logic [NCH-1:0]   pwm_n
);
    localparam int MODE_W = 2 * NCH;

    logic [MODE_W-1:0] modes;

    cpwm_keyreg #(
        .NCH   (NCH),
        .REG_W (REG_W),
        .KEY_W (8),
        .KEY   (8'h5A)
    ) keyreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .modes (modes)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        cpwm_chan #(
            .CW (DB_W)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pwm_raw[gi]),
            .gpio_in  (gpio_n_val[gi]),
            .mode     (nmode_e'(modes[2*gi +: 2])),
            .dead_len (dead_len),
            .p_out    (pwm_p[gi]),
            .n_out    (pwm_n[gi])
        );
    end
endmodule

// File: tb/cpwm_deadband_tb_top.sv
`timescale 1ns/1ps
module cpwm_deadband_tb_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  dead_len = '0;
    logic [3:0]  pwm_raw = '0;
    logic [3:0]  gpio_n_val = '0;
    logic [3:0]  pwm_p, pwm_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference model state
    logic [7:0] e_modes = '0;
    logic [3:0] e_raw   = '0;
    int         e_cnt [NCH];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    cpwm_deadband dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dead_len(dead_len), .pwm_raw(pwm_raw),
        .gpio_n_val(gpio_n_val), .pwm_p(pwm_p), .pwm_n(pwm_n)
    );

    task automatic check_outputs(input string tag);
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] m;
            logic dead, lvl, ep, en;
            m    = e_modes[2*c +: 2];
            dead = (e_cnt[c] != 0);
            lvl  = (m == 2'b01);
            ep   = dead ? lvl : e_raw[c];
            case (m)
                2'b00:   en = gpio_n_val[c];                 // R5
                2'b01:   en = dead ? 1'b1 : ~e_raw[c];        // R6
                2'b10:   en = dead ? 1'b0 : ~e_raw[c];        // R7
                default: en = dead ? 1'b0 : e_raw[c];         // R8
            endcase
            vectors++;
            if (pwm_p[c] !== ep || pwm_n[c] !== en) begin
                errors++;
                $display("FAIL %s R4/R9/R10/R11/R12 ch%0d mode=%b cnt=%0d: p,n=%b%b expected %b%b",
                         tag, c, m, e_cnt[c], pwm_p[c], pwm_n[c], ep, en);
            end
        end
        vectors++;
        if (cfg_rdata !== {24'h0, e_modes}) begin
            errors++;
            $display("FAIL %s R2 rdata=%h expected %h", tag, cfg_rdata, {24'h0, e_modes});
        end
    endtask

    // one clock: inputs already driven at negedge; model updates at posedge
    task automatic cyc(input logic [3:0] raw, input logic [3:0] g, input string tag);
        pwm_raw    = raw;
        gpio_n_val = g;
        @(posedge clk);
        if (cfg_we && cfg_wdata[31:24] == 8'h5A) e_modes = cfg_wdata[7:0];   // R1
        for (int c = 0; c < NCH; c++) begin
            if (raw[c] != e_raw[c] && dead_len != 0) e_cnt[c] = dead_len;
            else if (e_cnt[c] > 0) e_cnt[c] = e_cnt[c] - 1;
        end
        e_raw = raw;
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic reg_write(input logic [31:0] d, input string tag);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        cyc(pwm_raw, gpio_n_val, tag);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) e_cnt[c] = 0;
        repeat (3) @(negedge clk);
        gpio_n_val = 4'b1010;
        #1;
        check_outputs("R3 reset");
        rst_n = 1'b1;
        cyc(4'b0000, 4'b0101, "R3 after reset");

        // R1: wrong keys are ignored, seen through readback and the pins
        reg_write(32'h00FF_FFFF, "R1 key 00");
        reg_write(32'h5BFF_FFFF, "R1 key 5B");
        reg_write(32'hA5FF_FFFF, "R1 key A5");
        reg_write(32'hFFFF_FFFF, "R1 key FF");
        cyc(4'b0000, 4'b1111, "R1 modes still GPIO");
        // R2: key byte and reserved bits read back as zero
        reg_write(32'h5AFF_FFFF, "R2 all ones");
        reg_write(32'h5A00_0000, "R1 clear");
        // R4: each field in its own slot
        for (int c = 0; c < NCH; c++) begin
            reg_write(32'h5A00_0000 | (32'h3 << (2*c)), "R4 field slot");
            cyc(4'b0000, 4'b1111, "R4 field effect");
        end

        // pseudo-random sweep over mixed modes and lengths (R5-R8, R10, R12)
        foreach (lfsr[i]) begin end
        for (int k = 0; k < 6; k++) begin
            logic [7:0] cfgs [6] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'hE4, 8'h1B};
            reg_write({8'h5A, 16'h0, cfgs[k]}, "R4 mode select");
            for (int li = 0; li < 5; li++) begin
                logic [7:0] lens [5] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7};
                dead_len = lens[li];
                for (int t = 0; t < 120; t++) begin
                    logic [3:0] nr;
                    step_lfsr();
                    nr = pwm_raw;
                    for (int c = 0; c < NCH; c++)
                        if (lfsr[3*c +: 2] == 2'b00) nr[c] = ~nr[c];
                    cyc(nr, lfsr[15:12], "R10 R12 random");
                end
            end
        end

        // deterministic retrigger sweep (R9, R11)
        for (int k = 0; k < 2; k++) begin
            reg_write(k == 0 ? 32'h5A00_00E4 : 32'h5A00_0055, "R11 mode select");
            for (int l = 1; l <= 5; l++) begin
                dead_len = 8'(l);
                for (int gap = 1; gap <= l + 2; gap++) begin
                    for (int t = 0; t < 8 * (l + 4); t++) begin
                        logic [3:0] nr;
                        nr = pwm_raw;
                        for (int c = 0; c < NCH; c++)
                            if ((t % (gap + c)) == 0) nr[c] = ~nr[c];
                        cyc(nr, 4'(t), "R9 R11 spacing");
                    end
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule